// File: doc/BRIEF.md
# Q13.19 Fixed-Point Arithmetic Unit

This unit does arithmetic on 32-bit signed fixed-point words. Each word holds a sign and integer part of 13 bits and a fraction of 19 bits, so one unit of the raw integer is 2^-19. Each transaction carries two operands and an opcode. The unit can add, subtract, or multiply at full precision through a 64-bit product. It also has two cheaper multiply modes that shift both operands right before the product so that the product fits a 32-bit multiplier. The last two operations convert between IEEE 754 single precision (1 sign, 8 exponent, 23 mantissa bits) and the fixed-point format.

Operations enter and results leave on valid/ready streams. An input is taken on any clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid` at the next edge, for every opcode. The one-entry output register holds its data and flag steady while `out_ready` is low. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so back-pressure from the consumer stalls the producer at once and no result is lost. The overflow flag travels with each result.

Top module: `fxp_alu`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_data` and `out_ovf` are 0 until the first input is accepted.
- R2: An input is taken when `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` high on the next clock edge. `in_ready` equals `!out_valid || out_ready`. A presented result keeps its data and flag unchanged until a cycle with `out_ready` high. Results leave in the order the inputs were taken.
- R3: Opcode 0 gives a+b and opcode 1 gives a-b as plain 32-bit signed integer arithmetic. If the exact result does not fit in 32 bits, the output is clamped to 0x7FFFFFFF or 0x80000000 according to the sign of the exact result, and `out_ovf` is set.
- R4: Opcode 2 forms the exact 64-bit signed product and shifts it arithmetically right by 19, which rounds toward minus infinity. If that value does not fit in 32 bits, it is clamped as in R3 and `out_ovf` is set.
- R5: Opcode 3 is the high-range multiply. Each operand is shifted arithmetically right by 9, the two are multiplied keeping the low 32 bits, and the product is shifted arithmetically right by 1. `out_ovf` is 0.
- R6: Opcode 4 is the high-precision multiply. Each operand is shifted arithmetically right by 7, the two are multiplied keeping the low 32 bits, and the product is shifted arithmetically right by 5. `out_ovf` is 0.
- R7: Opcode 5 reads operand a as a single-precision float and returns value·2^19 truncated toward zero. `out_ovf` is 0 when the result is in range. The value -4096.0 gives exactly 0x80000000 with no overflow.
- R8: With opcode 5, an exponent field of 0 (zero or denormal) gives 0 with no overflow. Infinity, and any finite value whose scaled result falls outside the 32-bit range, gives 0x7FFFFFFF or 0x80000000 by sign with `out_ovf` set. NaN gives 0 with `out_ovf` set.
- R9: Opcode 6 converts operand a to the single-precision float of a·2^-19. The exponent is exact and the mantissa bits beyond 23 are truncated toward zero. A zero input gives +0.0 (0x00000000). `out_ovf` is 0.
- R10: Opcode 7 is reserved and gives `out_data` 0 with `out_ovf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 full mul, 3 high-range mul, 4 high-precision mul, 5 float to fixed, 6 fixed to float, 7 reserved) |
| in_a | input | 32 | First operand (fixed-point, or float bits for opcode 5) |
| in_b | input | 32 | Second operand (ignored by opcodes 5 and 6) |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result word |
| out_ovf | output | 1 | Overflow or invalid input for this result |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 19 fraction bits, and pre/post shifts of 9/1 and 7/5. At these widths the saturation corners at ±2^31 and the conversion boundary at ±4096.0 are reachable with short, hand-derived vectors. A scoreboard runs the same operations once with the consumer always ready and once with a repeating stall pattern, so in-order delivery and hold under back-pressure are tested against every opcode.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD       = 3'd0,
    OP_SUB       = 3'd1,
    OP_MUL_FULL  = 3'd2,
    OP_MUL_RANGE = 3'd3,
    OP_MUL_PREC  = 3'd4,
    OP_FLT2FX    = 3'd5,
    OP_FX2FLT    = 3'd6,
    OP_RESERVED  = 3'd7
  } op_e;

  // single-precision field layout
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;

endpackage

// File: rtl/fxp_mul_full.sv
module fxp_mul_full #(
  parameter int W = 32,
  parameter int F = 19
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic        [W-1:0] y,
  output logic                ovf
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic        [PW-W:0] upper;

  always_comb begin
    prod   = a * b;
    scaled = prod >>> F;
    upper  = scaled[PW-1:W-1];
    ovf    = !((&upper) || !(|upper));
    if (ovf) y = scaled[PW-1] ? SAT_MIN : SAT_MAX;
    else     y = scaled[W-1:0];
  end
endmodule

// File: rtl/fxp_mul_narrow.sv
module fxp_mul_narrow #(
  parameter int W    = 32,
  parameter int PRE  = 9,
  parameter int POST = 1
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic        [W-1:0] y
);
  logic signed [W-1:0] pa;
  logic signed [W-1:0] pb;
  logic signed [W-1:0] pr;

  always_comb begin
    pa = a >>> PRE;
    pb = b >>> PRE;
    pr = pa * pb;
    y  = pr >>> POST;
  end
endmodule

// File: rtl/fxp_from_float.sv
module fxp_from_float
  import fxp_pkg::*;
#(
  parameter int W = 32,
  parameter int F = 19
) (
  input  logic [31:0]  f,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam int MW       = W + 1;
  localparam int SHIFT_OF = F - SP_MAN_W - SP_BIAS;
  localparam int K_LIMIT  = W - SP_MAN_W;
  localparam logic [W-1:0]  SAT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  SAT_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [MW-1:0] MAG_POS = {2'b00, {(W-1){1'b1}}};
  localparam logic [MW-1:0] MAG_NEG = {2'b01, {(W-1){1'b0}}};

  logic                sgn;
  logic [SP_EXP_W-1:0] ex;
  logic [SP_MAN_W-1:0] fr;
  logic [MW-1:0]       sig;
  logic [MW-1:0]       mag;
  int                  k;

  always_comb begin
    sgn = f[31];
    ex  = f[30:SP_MAN_W];
    fr  = f[SP_MAN_W-1:0];
    sig = {{(MW-SP_MAN_W-1){1'b0}}, 1'b1, fr};
    k   = int'(ex) + SHIFT_OF;
    mag = '0;
    y   = '0;
    ovf = 1'b0;
    if (ex == '0) begin
      y = '0;
    end else if (ex == '1) begin
      ovf = 1'b1;
      y   = (fr != '0) ? '0 : (sgn ? SAT_MIN : SAT_MAX);
    end else if (k >= K_LIMIT) begin
      ovf = 1'b1;
      y   = sgn ? SAT_MIN : SAT_MAX;
    end else begin
      if (k >= 0) mag = sig << k;
      else        mag = sig >> (-k);
      if (!sgn) begin
        if (mag > MAG_POS) begin
          ovf = 1'b1;
          y   = SAT_MAX;
        end else begin
          y = mag[W-1:0];
        end
      end else begin
        if (mag > MAG_NEG) begin
          ovf = 1'b1;
          y   = SAT_MIN;
        end else begin
          y = (~mag[W-1:0]) + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fxp_to_float.sv
module fxp_to_float
  import fxp_pkg::*;
#(
  parameter int W = 32,
  parameter int F = 19
) (
  input  logic [W-1:0] x,
  output logic [31:0]  f
);
  logic [W-1:0]        mag;
  logic [W-1:0]        norm;
  logic [SP_EXP_W-1:0] ex;
  int                  p;

  always_comb begin
    mag = x[W-1] ? ((~x) + 1'b1) : x;
    p   = 0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) p = i;
    end
    norm = mag << (W - 1 - p);
    ex   = SP_EXP_W'(p - F + SP_BIAS);
    if (mag == '0) f = '0;
    else           f = {x[W-1], ex, norm[W-2 -: SP_MAN_W]};
  end
endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
  import fxp_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int FRAC_W   = 19,
  parameter int RNG_PRE  = 9,
  parameter int RNG_POST = 1,
  parameter int PRC_PRE  = 7,
  parameter int PRC_POST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_ovf
);
  localparam logic [WORD_W-1:0] SAT_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] SAT_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic signed [WORD_W:0] sum_w;
  logic signed [WORD_W:0] dif_w;
  logic [WORD_W-1:0] mulf_y, mulr_y, mulp_y, f2x_y, x2f_y;
  logic              mulf_ovf, f2x_ovf;
  logic [WORD_W-1:0] res_d;
  logic              ovf_d;
  logic              take;

  fxp_mul_full #(.W(WORD_W), .F(FRAC_W)) u_mul_full (
    .a(in_a), .b(in_b), .y(mulf_y), .ovf(mulf_ovf)
  );

  fxp_mul_narrow #(.W(WORD_W), .PRE(RNG_PRE), .POST(RNG_POST)) u_mul_range (
    .a(in_a), .b(in_b), .y(mulr_y)
  );

  fxp_mul_narrow #(.W(WORD_W), .PRE(PRC_PRE), .POST(PRC_POST)) u_mul_prec (
    .a(in_a), .b(in_b), .y(mulp_y)
  );

  fxp_from_float #(.W(WORD_W), .F(FRAC_W)) u_from_float (
    .f(in_a[31:0]), .y(f2x_y), .ovf(f2x_ovf)
  );

  fxp_to_float #(.W(WORD_W), .F(FRAC_W)) u_to_float (
    .x(in_a), .f(x2f_y)
  );

  always_comb begin
    sum_w = {in_a[WORD_W-1], in_a} + {in_b[WORD_W-1], in_b};
    dif_w = {in_a[WORD_W-1], in_a} - {in_b[WORD_W-1], in_b};
    res_d = '0;
    ovf_d = 1'b0;
    case (op_e'(in_op))
      OP_ADD: begin
        ovf_d = sum_w[WORD_W] != sum_w[WORD_W-1];
        res_d = ovf_d ? (sum_w[WORD_W] ? SAT_MIN : SAT_MAX) : sum_w[WORD_W-1:0];
      end
      OP_SUB: begin
        ovf_d = dif_w[WORD_W] != dif_w[WORD_W-1];
        res_d = ovf_d ? (dif_w[WORD_W] ? SAT_MIN : SAT_MAX) : dif_w[WORD_W-1:0];
      end
      OP_MUL_FULL: begin
        res_d = mulf_y;
        ovf_d = mulf_ovf;
      end
      OP_MUL_RANGE: res_d = mulr_y;
      OP_MUL_PREC:  res_d = mulp_y;
      OP_FLT2FX: begin
        res_d = f2x_y;
        ovf_d = f2x_ovf;
      end
      OP_FX2FLT:    res_d = x2f_y;
      default: begin
        res_d = '0;
        ovf_d = 1'b0;
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res_d;
      out_ovf   <= ovf_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fxp_alu_chk.sv
module fxp_alu_chk
  import fxp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_ovf
);
  logic [OP_W-1:0] held_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held_op <= OP_ADD;
    else if (in_valid && in_ready) held_op <= in_op;
  end

  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf));

  a_r2_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r5_range_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && held_op == OP_MUL_RANGE |-> !out_ovf);

  a_r6_prec_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && held_op == OP_MUL_PREC |-> !out_ovf);

  a_r9_tofloat_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && held_op == OP_FX2FLT |-> !out_ovf);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && held_op == OP_RESERVED |-> out_data == '0 && !out_ovf);
endmodule

bind fxp_alu fxp_alu_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/fxp_alu_bench.sv
`timescale 1ns/1ps
module fxp_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] d;
    logic        o;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  fxp_alu u_fxp_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected-value models written from the requirement text
  function automatic logic [32:0] m_addsub(input logic [31:0] a, input logic [31:0] b, input bit sub);
    longint s;
    s = sub ? (longint'($signed(a)) - longint'($signed(b))) : (longint'($signed(a)) + longint'($signed(b)));
    if (s > 64'sd2147483647)        return {1'b1, 32'h7FFFFFFF};
    else if (s < -64'sd2147483648)  return {1'b1, 32'h80000000};
    else                            return {1'b0, s[31:0]};
  endfunction

  function automatic logic [32:0] m_mulf(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = (longint'($signed(a)) * longint'($signed(b))) >>> 19;
    if (p > 64'sd2147483647)        return {1'b1, 32'h7FFFFFFF};
    else if (p < -64'sd2147483648)  return {1'b1, 32'h80000000};
    else                            return {1'b0, p[31:0]};
  endfunction

  function automatic logic [32:0] m_narrow(input logic [31:0] a, input logic [31:0] b, input int pre, input int post);
    int sa, sb2, pr;
    sa  = $signed(a) >>> pre;
    sb2 = $signed(b) >>> pre;
    pr  = sa * sb2;
    pr  = pr >>> post;
    return {1'b0, pr};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [32:0] e, input string tag);
    bit rdy;
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    while (1) begin
      #1 rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    it.d = e[31:0]; it.o = e[32]; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer ready pattern
  initial forever begin
    @(negedge clk);
    cyc++;
    out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit          stalled = 1'b0;
    logic [31:0] held_d = '0;
    logic        held_o = 1'b0;
    exp_t        it;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (stalled)
          check(out_valid && out_data == held_d && out_ovf == held_o, "R2 hold under stall",
                {out_ovf, out_data}, {held_o, held_d});
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected result", {out_ovf, out_data}, 33'd0);
          end else begin
            it = sb.pop_front();
            check(out_data == it.d && out_ovf == it.o, it.tag, {out_ovf, out_data}, {it.o, it.d});
          end
        end
        stalled = out_valid && !out_ready;
        held_d  = out_data;
        held_o  = out_ovf;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 33'd0, 33'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_set();
    // R3 add/sub
    drive(3'd0, 32'h00080000, 32'h00040000, m_addsub(32'h00080000, 32'h00040000, 0), "R3 add");
    drive(3'd0, 32'h7FFFFFFF, 32'h00000001, {1'b1, 32'h7FFFFFFF}, "R3 add pos sat");
    drive(3'd0, 32'h80000000, 32'hFFFFFFFF, {1'b1, 32'h80000000}, "R3 add neg sat");
    drive(3'd1, 32'h00000000, 32'h80000000, {1'b1, 32'h7FFFFFFF}, "R3 sub pos sat");
    drive(3'd1, 32'h80000000, 32'h00000001, {1'b1, 32'h80000000}, "R3 sub neg sat");
    drive(3'd1, 32'h00100000, 32'h00280000, m_addsub(32'h00100000, 32'h00280000, 1), "R3 sub");
    // R4 full multiply
    drive(3'd2, 32'h000C0000, 32'h00100000, {1'b0, 32'h00180000}, "R4 1.5*2.0");
    drive(3'd2, 32'h10000000, 32'h10000000, {1'b1, 32'h7FFFFFFF}, "R4 pos sat");
    drive(3'd2, 32'h10000000, 32'hF0000000, {1'b1, 32'h80000000}, "R4 neg sat");
    drive(3'd2, 32'hFFFFFFFF, 32'h00000001, {1'b0, 32'hFFFFFFFF}, "R4 floor rounding");
    // R5 / R6 reduced multiplies
    drive(3'd3, 32'h000C0000, 32'h00100000, {1'b0, 32'h00180000}, "R5 1.5*2.0");
    drive(3'd4, 32'h000C0000, 32'h00100000, {1'b0, 32'h00180000}, "R6 1.5*2.0");
    drive(3'd3, 32'hFFF80000, 32'h00123456, m_narrow(32'hFFF80000, 32'h00123456, 9, 1), "R5 negative");
    drive(3'd4, 32'hFFF80000, 32'h00123456, m_narrow(32'hFFF80000, 32'h00123456, 7, 5), "R6 negative");
    drive(3'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, m_narrow(32'h7FFFFFFF, 32'h7FFFFFFF, 9, 1), "R5 wrap no flag");
    // R7 float to fixed
    drive(3'd5, 32'h3F800000, 32'hDEADBEEF, {1'b0, 32'h00080000}, "R7 1.0");
    drive(3'd5, 32'hC0200000, 32'h0, {1'b0, 32'hFFEC0000}, "R7 -2.5");
    drive(3'd5, 32'h3DCCCCCD, 32'h0, {1'b0, 32'h0000CCCC}, "R7 0.1 truncated");
    drive(3'd5, 32'hBDCCCCCD, 32'h0, {1'b0, 32'hFFFF3334}, "R7 -0.1 toward zero");
    drive(3'd5, 32'h36000000, 32'h0, {1'b0, 32'h00000001}, "R7 one lsb");
    drive(3'd5, 32'hC5800000, 32'h0, {1'b0, 32'h80000000}, "R7 -4096 exact");
    // R8 float specials
    drive(3'd5, 32'h00000001, 32'h0, {1'b0, 32'h00000000}, "R8 denormal");
    drive(3'd5, 32'h80000000, 32'h0, {1'b0, 32'h00000000}, "R8 minus zero");
    drive(3'd5, 32'h2F000000, 32'h0, {1'b0, 32'h00000000}, "R8 tiny");
    drive(3'd5, 32'h45800000, 32'h0, {1'b1, 32'h7FFFFFFF}, "R8 +4096 sat");
    drive(3'd5, 32'hC6000000, 32'h0, {1'b1, 32'h80000000}, "R8 -8192 sat");
    drive(3'd5, 32'h7F800000, 32'h0, {1'b1, 32'h7FFFFFFF}, "R8 +inf");
    drive(3'd5, 32'hFF800000, 32'h0, {1'b1, 32'h80000000}, "R8 -inf");
    drive(3'd5, 32'h7FC00000, 32'h0, {1'b1, 32'h00000000}, "R8 NaN");
    // R9 fixed to float
    drive(3'd6, 32'h00080000, 32'h12345678, {1'b0, 32'h3F800000}, "R9 1.0");
    drive(3'd6, 32'h00000000, 32'h0, {1'b0, 32'h00000000}, "R9 zero");
    drive(3'd6, 32'h00000001, 32'h0, {1'b0, 32'h36000000}, "R9 one lsb");
    drive(3'd6, 32'hFFEC0000, 32'h0, {1'b0, 32'hC0200000}, "R9 -2.5");
    drive(3'd6, 32'h7FFFFFFF, 32'h0, {1'b0, 32'h457FFFFF}, "R9 max truncated");
    drive(3'd6, 32'h80000000, 32'h0, {1'b0, 32'hC5800000}, "R9 min");
    drive(3'd6, 32'h0000CCCC, 32'h0, {1'b0, 32'h3DCCCC00}, "R9 0.1");
    // R10 reserved
    drive(3'd7, 32'h12345678, 32'h9ABCDEF0, {1'b0, 32'h00000000}, "R10 reserved");
    // mixed operand patterns
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      drive(3'd0, a, b, m_addsub(a, b, 0), "R3 add mix");
      drive(3'd1, a, b, m_addsub(a, b, 1), "R3 sub mix");
      drive(3'd2, a >>> 8, b, m_mulf(a >>> 8, b), "R4 mul mix");
      drive(3'd3, a, b, m_narrow(a, b, 9, 1), "R5 mul mix");
      drive(3'd4, a, b, m_narrow(a, b, 7, 5), "R6 mul mix");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && out_data == '0 && out_ovf == 1'b0, "R1 in reset",
          {out_ovf, out_data}, 33'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(out_valid == 1'b0 && out_data == '0 && out_ovf == 1'b0 && in_ready == 1'b1,
          "R1 after release", {out_ovf, out_data}, 33'd0);
    run_set();
    idle();
    repeat (4) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R2 drains when idle", {32'd0, out_valid}, 33'd0);
    bp_mode = 1'b1;
    run_set();
    idle();
    while (sb.size() != 0 || out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule